// File: doc/BRIEF.md
# Stable-Value SPI Register Reader

This block is a host-side SPI master. It fetches one register from a serial peripheral whose output word can change while it is being read. A single read can catch a value that is changing partway through. The controller therefore repeats the read frame until two back-to-back frames return the same word. It hands that word to the host together with a one-cycle done strobe.

The host pulses `start` with a 5-bit register address. Each frame has three parts. First an 8-bit header goes out, made of the address, a two-bit read opcode and one filler bit. Next, the peripheral's status flag is sampled at the eighth clock. Last, a 16-bit right-justified data word is clocked in. A cleared status flag ends the operation at once with an error. The operation also fails if a configurable number of frames pass without a matching pair. Chip select is released after every frame and stays high for a fixed quiet time before the next frame begins.

Top module: `stable_rd_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done` and `err` are 0, `spi_cs_n` is 1, `spi_sck` is 0 and `rd_data` is 0.
- R2: A full frame is 24 SCK rising edges while `spi_cs_n` is low. SCK idles low. MOSI changes only while SCK is low, and MISO is sampled on the rising edge. The first 8 MOSI bits, MSB first, are `addr[4:0]`, then 1, 1, then 0. The remaining 16 MOSI bits are 0.
- R3: The MISO bit sampled at the 8th rising edge is a status flag. If it is 0, the controller stops after that 8th bit, raises `spi_cs_n` and ends with `done` and `err` both high. No further frame is sent and `rd_data` keeps its previous value.
- R4: MISO bits 9 to 24 of a frame, MSB first, form the 16-bit data word, used with no shift or mask.
- R5: Frames repeat until the word of a frame equals the word of the frame just before it. The controller then ends with `done`=1, `err`=0 and that word on `rd_data`, and starts no further frame.
- R6: If `MAX_READS` frames (default 8) complete without two consecutive equal words, the operation ends with `done` and `err` both high, and `rd_data` keeps its previous value.
- R7: Between two frames of one operation, `spi_cs_n` stays high for at least `GAP_SCK` SCK periods (default 2, that is 8 clock cycles with the default divider).
- R8: `addr` is captured on the `start` cycle. A `start` pulse while `busy` is high is ignored: it causes no extra frame and does not change the address used.
- R9: `busy` is high from the cycle after an accepted `start` until the operation ends. `done` is a single-cycle pulse during which `busy` is already 0, and `err` is high only while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a stable read |
| addr | input | 5 | Register address, sampled with `start` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Failure flag, valid with `done` |
| rd_data | output | 16 | Last stable word read |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the peripheral |
| spi_miso | input | 1 | Serial data from the peripheral |

## Verification
The assertions assume two things. First, `rst_n` is held low for at least one clock edge before any activity. Second, MISO is allowed to change at any time, because the controller samples it only at its own rising-SCK ticks, never on a free-running edge. The bench's peripheral model drives MISO only from falling SCK edges, so each sampled bit has been stable for half an SCK period. Addresses with the top bit set act as unimplemented registers in that model, which exercises the status-failure path. Returned words come from small value pools, so that matching and non-matching neighbours both occur often.

// File: rtl/stable_rd_pkg.sv
// Shared types and constants for the stable-value SPI reader.
// Assumes: the header opcode for a read is the two-bit value 2'b11.
package stable_rd_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_SHIFT = 2'd1,
        SEQ_GAP   = 2'd2
    } seq_state_t;

    localparam logic [1:0] RD_OPCODE = 2'b11;
    localparam int         HDR_PAD_W = 3;   // opcode bits plus one filler bit
endpackage

// File: rtl/sck_tick_gen.sv
// Half-period tick generator for the serial clock.
// Emits a one-cycle tick every DIV system clocks while run is high.
// Assumes: DIV >= 1; restarting run realigns the count to zero.
module sck_tick_gen #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    // Count system clocks within one half SCK period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == CW'(DIV - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == CW'(DIV - 1));
endmodule

// File: rtl/frame_shifter.sv
// Shift engine for one read frame: serialises the header and collects MISO.
// Assumes: load, rise and fall are mutually exclusive single-cycle strobes.
module frame_shifter
    import stable_rd_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          load,
    input  logic [ADDR_W-1:0]                             addr,
    input  logic                                          rise,
    input  logic                                          fall,
    input  logic                                          miso,
    output logic                                          mosi,
    output logic [$clog2(ADDR_W+HDR_PAD_W+DATA_W+1)-1:0]  bit_cnt,
    output logic [DATA_W-1:0]                             rx
);
    localparam int FRAME_W = ADDR_W + HDR_PAD_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] tx;

    // Transmit register: loaded with header, advanced after each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx <= '0;
        end else if (load) begin
            tx <= {addr, RD_OPCODE, 1'b0, {DATA_W{1'b0}}};
        end else if (fall) begin
            tx <= {tx[FRAME_W-2:0], 1'b0};
        end
    end

    // Receive register and bit counter: one MISO sample per rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            rx      <= '0;
            bit_cnt <= '0;
        end else if (rise) begin
            rx      <= {rx[DATA_W-2:0], miso};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    assign mosi = tx[FRAME_W-1];

    AST_CNT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(FRAME_W)); // R2
    AST_TX_STILL_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> $stable(mosi)); // R2
endmodule

// File: rtl/match_tracker.sv
// Keeps the previous frame word and the number of frames read so far.
// same: the offered word equals the previous one; last: this frame is the final allowed one.
// Assumes: MAX_READS >= 2; push is issued once per completed frame.
module match_tracker #(
    parameter int DATA_W    = 16,
    parameter int MAX_READS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic [DATA_W-1:0] word,
    output logic              same,
    output logic              last
);
    localparam int CW = $clog2(MAX_READS + 1);

    logic [DATA_W-1:0] prev;
    logic [CW-1:0]     reads;

    // Remember the latest word and count completed frames.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            prev  <= '0;
            reads <= '0;
        end else if (push) begin
            prev <= word;
            if (reads < CW'(MAX_READS)) begin
                reads <= reads + 1'b1;
            end
        end
    end

    assign same = (reads != '0) && (word == prev);
    assign last = (reads >= CW'(MAX_READS - 1));

    AST_READS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        reads <= CW'(MAX_READS)); // R6
    AST_NO_PUSH_PAST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (reads == CW'(MAX_READS)) |-> !push); // R6
endmodule

// File: rtl/stable_rd_ctrl.sv
// Stable-value SPI read controller (mode 0). Sends read frames to one address
// until two consecutive data words agree, then reports that word.
// Assumes: peripheral returns a status bit at clock HDR_W and right-justified data after it.
module stable_rd_ctrl
    import stable_rd_pkg::*;
#(
    parameter int CLK_DIV   = 2,
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int MAX_READS = 8,
    parameter int GAP_SCK   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rd_data,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int HDR_W     = ADDR_W + HDR_PAD_W;
    localparam int FRAME_W   = HDR_W + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_W + 1);
    localparam int GAP_TICKS = 2 * GAP_SCK;
    localparam int GW        = $clog2(GAP_TICKS + 1);

    seq_state_t        state;
    logic              tick;
    logic              rise, fall;
    logic              accept, reload, push;
    logic              status_fail, frame_end;
    logic              same, last;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] rx;
    logic [GW-1:0]     gap_cnt;

    assign busy        = (state != SEQ_IDLE);
    assign accept      = (state == SEQ_IDLE) && start;
    assign rise        = (state == SEQ_SHIFT) && tick && !spi_sck;
    assign fall        = (state == SEQ_SHIFT) && tick && spi_sck;
    assign status_fail = (bit_cnt == CNT_W'(HDR_W)) && !rx[0];
    assign frame_end   = (bit_cnt == CNT_W'(FRAME_W));
    assign push        = fall && frame_end;
    assign reload      = (state == SEQ_GAP) && tick && (gap_cnt == GW'(GAP_TICKS - 1));

    sck_tick_gen #(.DIV(CLK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    frame_shifter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept || reload),
        .addr    (accept ? addr : addr_q),
        .rise    (rise),
        .fall    (fall),
        .miso    (spi_miso),
        .mosi    (spi_mosi),
        .bit_cnt (bit_cnt),
        .rx      (rx)
    );

    match_tracker #(.DATA_W(DATA_W), .MAX_READS(MAX_READS)) u_match (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .push  (push),
        .word  (rx),
        .same  (same),
        .last  (last)
    );

    logic [ADDR_W-1:0] addr_q;

    // Hold the address of the running operation for later frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (accept) begin
            addr_q <= addr;
        end
    end

    // Sequencer: serial clock level, chip select, frame gaps and result reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            spi_sck  <= 1'b0;
            spi_cs_n <= 1'b1;
            done     <= 1'b0;
            err      <= 1'b0;
            rd_data  <= '0;
            gap_cnt  <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        spi_cs_n <= 1'b0;
                        spi_sck  <= 1'b0;
                        state    <= SEQ_SHIFT;
                    end
                end
                SEQ_SHIFT: begin
                    if (rise) begin
                        spi_sck <= 1'b1;
                    end else if (fall) begin
                        spi_sck <= 1'b0;
                        if (status_fail) begin
                            spi_cs_n <= 1'b1;
                            state    <= SEQ_IDLE;
                            done     <= 1'b1;
                            err      <= 1'b1;
                        end else if (frame_end) begin
                            spi_cs_n <= 1'b1;
                            if (same) begin
                                state   <= SEQ_IDLE;
                                done    <= 1'b1;
                                rd_data <= rx;
                            end else if (last) begin
                                state <= SEQ_IDLE;
                                done  <= 1'b1;
                                err   <= 1'b1;
                            end else begin
                                state   <= SEQ_GAP;
                                gap_cnt <= '0;
                            end
                        end
                    end
                end
                SEQ_GAP: begin
                    if (tick) begin
                        if (reload) begin
                            spi_cs_n <= 1'b0;
                            state    <= SEQ_SHIFT;
                        end else begin
                            gap_cnt <= gap_cnt + 1'b1;
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_cs_n); // R9
    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck); // R2
    AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && !spi_cs_n) |-> $stable(spi_mosi)); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done); // R9
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9
    AST_DATA_ONLY_ON_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> (done && !err)); // R3
    AST_CS_RISE_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> !spi_sck); // R7
endmodule

// File: tb/stable_rd_ctrl_bench.sv
module stable_rd_ctrl_bench;
    localparam int CLK_DIV   = 2;
    localparam int MAX_READS = 8;
    localparam int GAP_SCK   = 2;
    localparam int MIN_GAP   = GAP_SCK * 2 * CLK_DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  addr = '0;
    logic        miso = 1'b0;
    logic        busy, done, err, sck, cs_n, mosi;
    logic [15:0] rd_data;

    always #5 clk = ~clk;

    stable_rd_ctrl #(.CLK_DIV(CLK_DIV), .MAX_READS(MAX_READS), .GAP_SCK(GAP_SCK)) u_stable_rd_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .addr(addr),
        .busy(busy), .done(done), .err(err), .rd_data(rd_data),
        .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso)
    );

    int errors = 0;
    int checks = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- peripheral model ----------------
    logic [15:0] resp [0:15];
    logic [7:0]  exp_hdr = '0;
    logic [7:0]  hdr_rx = '0;
    bit          mon_on = 0;
    bit          stat_ok = 0;
    int          rise_n = 0;
    int          frames_seen = 0;
    int          hdr_bad = 0, tail_bad = 0, rise_bad = 0, gap_bad = 0;
    bit          in_gap = 0;
    int          gap_len = 0;

    always @(negedge cs_n) begin
        if (mon_on) begin
            rise_n = 0;
            hdr_rx = '0;
            stat_ok = 0;
            if (in_gap && gap_len < MIN_GAP) gap_bad++;
            in_gap = 0;
        end
    end

    always @(posedge cs_n) begin
        if (mon_on) begin
            if (rise_n != (stat_ok ? 24 : 8)) rise_bad++;
            frames_seen++;
            in_gap = 1;
            gap_len = 0;
        end
    end

    always @(posedge sck) begin
        if (mon_on && cs_n === 1'b0) begin
            if (rise_n < 8) hdr_rx = {hdr_rx[6:0], mosi};
            else if (mosi !== 1'b0) tail_bad++;
            rise_n++;
            if (rise_n == 8 && hdr_rx !== exp_hdr) hdr_bad++;
        end
    end

    always @(negedge sck) begin
        if (mon_on && cs_n === 1'b0) begin
            if (rise_n == 7) begin
                stat_ok = (hdr_rx[6] == 1'b0) && (hdr_rx[1:0] == 2'b11);
                miso = stat_ok;
            end else if (rise_n >= 8 && rise_n <= 23) begin
                miso = stat_ok ? resp[frames_seen][23 - rise_n] : 1'b0;
            end else begin
                miso = 1'b0;
            end
        end
    end

    always @(negedge clk) begin
        if (mon_on && cs_n && in_gap) gap_len++;
    end

    // ---------------- expected-value model ----------------
    function automatic void model(input logic [4:0] a, output bit e_err,
                                  output logic [15:0] e_val, output int e_frames);
        e_val = '0;
        if (a[4]) begin
            e_err = 1; e_frames = 1; return;
        end
        for (int i = 1; i < MAX_READS; i++) begin
            if (resp[i] == resp[i-1]) begin
                e_err = 0; e_val = resp[i]; e_frames = i + 1; return;
            end
        end
        e_err = 1; e_frames = MAX_READS;
    endfunction

    logic [15:0] last_good = '0;

    task automatic run_txn(input logic [4:0] a, input bit poke);
        bit          e_err;
        logic [15:0] e_val;
        int          e_frames;
        int          cyc;
        int          fr_after;
        model(a, e_err, e_val, e_frames);
        exp_hdr = {a, 3'b110};
        frames_seen = 0; hdr_bad = 0; tail_bad = 0; rise_bad = 0; gap_bad = 0; in_gap = 0;
        @(negedge clk);
        addr = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0; addr = 5'($urandom);
        check(busy === 1'b1, "R9", "busy after start", 32'(busy), 1);
        cyc = 0;
        while (done !== 1'b1 && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 50) begin start = 1'b1; addr = ~a; end
            else start = 1'b0;
        end
        start = 1'b0;
        check(done === 1'b1, "R9", "done seen", 32'(done), 1);
        check(busy === 1'b0, "R9", "busy low at done", 32'(busy), 0);
        check(err === e_err, e_err ? "R6" : "R5", "err flag", 32'(err), 32'(e_err));
        if (a[4]) check(err === 1'b1, "R3", "status failure", 32'(err), 1);
        if (!e_err) begin
            check(rd_data === e_val, "R4", "stable word", 32'(rd_data), 32'(e_val));
            last_good = e_val;
        end else begin
            check(rd_data === last_good, "R3", "word kept on error", 32'(rd_data), 32'(last_good));
        end
        check(frames_seen == e_frames, e_err ? "R6" : "R5", "frame count", 32'(frames_seen), 32'(e_frames));
        check(hdr_bad == 0, poke ? "R8" : "R2", "header bits", 32'(hdr_bad), 0);
        check(tail_bad == 0, "R2", "MOSI zero after header", 32'(tail_bad), 0);
        check(rise_bad == 0, "R2", "rising edges per frame", 32'(rise_bad), 0);
        check(gap_bad == 0, "R7", "CS high gap", 32'(gap_bad), 0);
        @(negedge clk);
        check(done === 1'b0 && err === 1'b0, "R9", "done one cycle", 32'({done, err}), 0);
        fr_after = frames_seen;
        repeat (30) @(negedge clk);
        check(busy === 1'b0 && frames_seen == fr_after, "R8", "no extra frame", 32'(frames_seen), 32'(fr_after));
    endtask

    task automatic fill_distinct(input logic [15:0] base);
        for (int i = 0; i < 16; i++) resp[i] = base + 16'(i * 16'h0111);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        for (int i = 0; i < 16; i++) resp[i] = '0;
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R1", "reset flags", 32'({busy, done, err}), 0);
        check(cs_n === 1'b1 && sck === 1'b0, "R1", "reset SPI pins", 32'({cs_n, sck}), 32'h2);
        check(rd_data === 16'h0, "R1", "reset data", 32'(rd_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1;

        // Directed: immediate match
        fill_distinct(16'h1000); resp[0] = 16'hA5C3; resp[1] = 16'hA5C3;
        run_txn(5'h03, 0);
        // All ones word (R4)
        fill_distinct(16'h2000); resp[0] = 16'hFFFF; resp[1] = 16'hFFFF;
        run_txn(5'h0A, 0);
        // Match on third frame
        fill_distinct(16'h3000); resp[0] = 16'h1234; resp[1] = 16'h5678; resp[2] = 16'h5678;
        run_txn(5'h0F, 0);
        // Never matches: limit reached (R6)
        for (int i = 0; i < 16; i++) resp[i] = (i % 2 == 0) ? 16'h0F0F : 16'hF0F0;
        run_txn(5'h05, 0);
        // Match exactly on the last allowed frame
        fill_distinct(16'h4000); resp[MAX_READS-2] = 16'h0001; resp[MAX_READS-1] = 16'h0001;
        run_txn(5'h00, 0);
        // Unimplemented address: status failure (R3)
        fill_distinct(16'h5000); resp[0] = 16'h7777; resp[1] = 16'h7777;
        run_txn(5'h1C, 0);
        // Start while busy is ignored (R8)
        fill_distinct(16'h6000); resp[2] = 16'hBEEF; resp[3] = 16'hBEEF;
        run_txn(5'h0C, 1);
        // Zero word match
        fill_distinct(16'h7000); resp[0] = 16'h0000; resp[1] = 16'h0000;
        run_txn(5'h01, 0);

        // Random mix
        for (int t = 0; t < 40; t++) begin
            logic [15:0] pool [0:2];
            logic [4:0]  a;
            for (int k = 0; k < 3; k++) pool[k] = 16'($urandom);
            for (int i = 0; i < 16; i++) begin
                if (i > 0 && ($urandom % 4) == 0) resp[i] = resp[i-1];
                else resp[i] = pool[$urandom % 3];
            end
            a = 5'($urandom);
            if (($urandom % 8) != 0) a[4] = 1'b0;
            run_txn(a, ($urandom % 6) == 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule